// File: doc/BRIEF.md
# Sleep-Entry PLL Shutdown Sequencer

This block decides the moment at which the main system PLL may be switched off when the chip goes to sleep. A software sleep request starts it. The sequencer first asks the system-bus arbiter for ownership of the bus. It then waits until three handshakes are all true in the same cycle:

- the bus grant,
- the processor platform's clock-off indication,
- the SDRAM controller's acknowledge that external memory is in self-refresh.

Only then does a settle countdown begin. The countdown is loaded from a programmable count field. The PLL disable output rises only when that countdown completes. If any handshake drops during the countdown, the countdown is abandoned and reloaded.

Once the PLL is off, a wake event re-enables it at once. The sequencer keeps the bus for a programmable relock delay, then releases it and returns to idle. A three-bit status output shows the current phase, for software and for checking.

Top module: `pll_sleep_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is idle: status 0, pll_off low and bus_req low.
- R2: sleep_req high in idle moves the sequencer to the bus-request phase (status 1) on the next cycle with bus_req high. It stays there until bus_grant is seen.
- R3: After the grant, the sequencer waits in status 2 until bus_grant, cpu_clk_off and sdram_sr_ack are all high in the same cycle. No countdown starts before that.
- R4: With a non-zero settle_cnt N, the cycle in which all three handshakes are first seen together in status 2 is followed by N cycles of status 3. pll_off rises in the cycle after those N cycles, provided all three handshakes stay high throughout.
- R5: A settle_cnt of zero makes pll_off rise on the cycle right after the three handshakes are seen together, with no counting phase.
- R6: If any handshake is low in a counting cycle, the sequencer returns to status 2. A later countdown starts again from the full settle_cnt.
- R7: wake_evt in status 1, 2 or 3 abandons the sequence. The next cycle is idle with bus_req low and pll_off low.
- R8: In status 4 (PLL off), pll_off stays high and bus_req stays high whatever the three handshakes and sleep_req do, until wake_evt.
- R9: wake_evt in status 4 drops pll_off on the next cycle and enters relock (status 5) with bus_req held high. With relock_cnt L, relock lasts L+1 cycles, then the sequencer is idle.
- R10: The status output encodes the phases as follows: 0 idle, 1 bus request, 2 wait for handshakes, 3 counting, 4 PLL off, 5 relock. No other value appears.
- R11: In idle, wake_evt and the three handshakes have no effect: status stays 0 and bus_req and pll_off stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Software request to enter sleep |
| wake_evt | input | 1 | Wake event |
| bus_grant | input | 1 | Grant from the system-bus arbiter |
| cpu_clk_off | input | 1 | Processor platform clock-off indication |
| sdram_sr_ack | input | 1 | SDRAM self-refresh acknowledge |
| settle_cnt | input | CNT_W | Settle countdown length from the control register |
| relock_cnt | input | LOCK_W | Relock delay length |
| bus_req | output | 1 | Bus request to the arbiter |
| pll_off | output | 1 | PLL disable |
| state_o | output | 3 | Current phase code |

## Verification
Every result of this block is one register stage from the inputs that cause it. A change of phase, bus request or PLL disable is due on the cycle right after the edge at which the stimulus was sampled. A countdown of N therefore shows pll_off N+1 cycles after the handshakes align, and a relock of L returns to idle L+1 cycles after entry. The bench holds inputs stable across each rising edge and steps a behavioural model at that same edge. It compares all three outputs against the model in the following low phase, so every expected value is sampled in exactly the cycle it is due.

// File: rtl/pll_sleep_seq.sv
module pll_sleep_seq #(
  parameter int CNT_W  = 8,
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              wake_evt,
  input  logic              bus_grant,
  input  logic              cpu_clk_off,
  input  logic              sdram_sr_ack,
  input  logic [CNT_W-1:0]  settle_cnt,
  input  logic [LOCK_W-1:0] relock_cnt,
  output logic              bus_req,
  output logic              pll_off,
  output logic [2:0]        state_o
);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_BREQ  = 3'd1;
  localparam logic [2:0] S_WAIT  = 3'd2;
  localparam logic [2:0] S_COUNT = 3'd3;
  localparam logic [2:0] S_OFF   = 3'd4;
  localparam logic [2:0] S_RLCK  = 3'd5;
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
  localparam logic [LOCK_W-1:0] LOCK_ZERO = '0;

  logic [2:0]        st;
  logic [CNT_W-1:0]  cnt;
  logic [LOCK_W-1:0] lcnt;
  logic              all_ok;

  assign all_ok  = bus_grant & cpu_clk_off & sdram_sr_ack;
  assign bus_req = (st != S_IDLE);
  assign pll_off = (st == S_OFF);
  assign state_o = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      lcnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (sleep_req) st <= S_BREQ;
        S_BREQ:
          if (wake_evt) st <= S_IDLE;
          else if (bus_grant) st <= S_WAIT;
        S_WAIT:
          if (wake_evt) st <= S_IDLE;
          else if (all_ok) begin
            cnt <= settle_cnt;
            st  <= (settle_cnt == '0) ? S_OFF : S_COUNT;
          end
        S_COUNT:
          if (wake_evt) st <= S_IDLE;
          else if (!all_ok) st <= S_WAIT;
          else if (cnt == CNT_ONE) st <= S_OFF;
          else cnt <= cnt - CNT_ONE;
        S_OFF:
          if (wake_evt) begin
            lcnt <= relock_cnt;
            st   <= S_RLCK;
          end
        S_RLCK:
          if (lcnt == LOCK_ZERO) st <= S_IDLE;
          else lcnt <= lcnt - LOCK_W'(1);
        default:
          st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_sleep_seq_chk.sv
module pll_sleep_seq_chk #(
  parameter int CNT_W  = 8,
  parameter int LOCK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic              wake_evt,
  input logic              bus_grant,
  input logic              cpu_clk_off,
  input logic              sdram_sr_ack,
  input logic [CNT_W-1:0]  settle_cnt,
  input logic [LOCK_W-1:0] relock_cnt,
  input logic              bus_req,
  input logic              pll_off,
  input logic [2:0]        state_o
);

  logic all3;
  assign all3 = bus_grant & cpu_clk_off & sdram_sr_ack;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (state_o == 3'd0 && !pll_off && !bus_req));

  p_sleep_reqs_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && sleep_req) |=> (bus_req && state_o == 3'd1));

  p_off_needs_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_off) |-> $past(all3));

  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && all3 && !wake_evt && settle_cnt == '0) |=> pll_off);

  p_drop_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !all3 && !wake_evt) |=> (state_o == 3'd2));

  p_abandon_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && state_o != 3'd0 && state_o < 3'd4) |=> (state_o == 3'd0 && !bus_req));

  p_off_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_off && !wake_evt) |=> (pll_off && bus_req));

  p_wake_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_off && wake_evt) |=> (!pll_off && bus_req && state_o == 3'd5));

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);

endmodule

bind pll_sleep_seq pll_sleep_seq_chk #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
  .bus_grant(bus_grant), .cpu_clk_off(cpu_clk_off), .sdram_sr_ack(sdram_sr_ack),
  .settle_cnt(settle_cnt), .relock_cnt(relock_cnt), .bus_req(bus_req),
  .pll_off(pll_off), .state_o(state_o)
);

// File: tb/pll_sleep_seq_tb_top.sv
`timescale 1ns/1ps
module pll_sleep_seq_tb_top;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0, sleep_req = 0, wake_evt = 0;
  logic bus_grant = 0, cpu_clk_off = 0, sdram_sr_ack = 0;
  logic [7:0] settle_cnt = 0, relock_cnt = 0;
  logic bus_req, pll_off;
  logic [2:0] state_o;

  pll_sleep_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .bus_grant(bus_grant), .cpu_clk_off(cpu_clk_off), .sdram_sr_ack(sdram_sr_ack),
    .settle_cnt(settle_cnt), .relock_cnt(relock_cnt), .bus_req(bus_req),
    .pll_off(pll_off), .state_o(state_o)
  );

  int vectors = 0, bad = 0;
  bit done = 0;
  string tag = "R1";
  int ph = 0, elapsed = 0, relapsed = 0, n_set = 0, l_set = 0;

  task automatic model_step();
    bit ok = bus_grant && cpu_clk_off && sdram_sr_ack;
    if (!rst_n) begin ph = 0; return; end
    case (ph)
      0: if (sleep_req) ph = 1;
      1: if (wake_evt) ph = 0; else if (bus_grant) ph = 2;
      2: if (wake_evt) ph = 0;
         else if (ok) begin
           n_set = settle_cnt; elapsed = 0;
           ph = (n_set == 0) ? 4 : 3;
         end
      3: if (wake_evt) ph = 0;
         else if (!ok) ph = 2;
         else begin elapsed++; if (elapsed == n_set) ph = 4; end
      4: if (wake_evt) begin l_set = relock_cnt; relapsed = 0; ph = 5; end
      5: if (relapsed == l_set) ph = 0; else relapsed++;
      default: ph = 0;
    endcase
  endtask

  task automatic compare();
    logic exp_off = (ph == 4);
    logic exp_req = (ph != 0);
    vectors++;
    if (state_o !== 3'(ph)) begin
      bad++;
      $display("FAIL R10 (%s): state_o=%0d expected %0d", tag, state_o, ph);
    end
    if (pll_off !== exp_off) begin
      bad++;
      $display("FAIL %s: pll_off=%b expected %b", tag, pll_off, exp_off);
    end
    if (bus_req !== exp_req) begin
      bad++;
      $display("FAIL %s: bus_req=%b expected %b", tag, bus_req, exp_req);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic hs(input logic g, input logic c, input logic s);
    bus_grant = g; cpu_clk_off = c; sdram_sr_ack = s;
  endtask

  task automatic go_sleep();
    sleep_req = 1; tick(1); sleep_req = 0;
  endtask

  task automatic wake();
    wake_evt = 1; tick(1); wake_evt = 0;
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; rst_n = 0; sleep_req = 1; tick(3);
    sleep_req = 0; rst_n = 1; tick(2);

    tag = "R11"; wake_evt = 1; hs(1, 1, 1); tick(3); wake_evt = 0; hs(0, 0, 0); tick(1);

    tag = "R2"; settle_cnt = 5; relock_cnt = 3; go_sleep(); tick(3);
    tag = "R3"; bus_grant = 1; tick(2); cpu_clk_off = 1; tick(2);
    sdram_sr_ack = 1; cpu_clk_off = 0; tick(2); cpu_clk_off = 1;
    tag = "R4"; tick(8);
    tag = "R8"; hs(0, 0, 0); sleep_req = 1; tick(4); sleep_req = 0;
    tag = "R9"; wake(); tick(6);

    tag = "R5"; settle_cnt = 0; relock_cnt = 0; hs(1, 1, 1);
    go_sleep(); tick(3); wake(); tick(3);

    tag = "R6"; settle_cnt = 4; relock_cnt = 2; hs(1, 1, 1);
    go_sleep(); tick(3); sdram_sr_ack = 0; tick(2); sdram_sr_ack = 1; tick(2);
    bus_grant = 0; tick(1); bus_grant = 1; tick(7);
    tag = "R9"; wake(); tick(4);

    tag = "R7"; hs(0, 0, 0); settle_cnt = 6;
    go_sleep(); tick(2); wake(); tick(2);
    go_sleep(); bus_grant = 1; tick(2); wake(); tick(2);
    go_sleep(); hs(1, 1, 1); tick(3); wake(); tick(3);

    tag = "R1"; go_sleep(); tick(4); rst_n = 0; tick(2); rst_n = 1; hs(0, 0, 0); tick(2);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule